// File: doc/BRIEF.md
# Port-Bus Peripheral Address Decoder

This block sits between the 8-bit port bus of a small soft processor and three local storage devices: a 64-word by 8-bit memory, one 8-bit data register and a single flag flip-flop. The processor presents a port number together with output data and a write pulse, or it presents a port number alone and picks up read data. The block decodes the port number, gates the write pulse into exactly one device, and steers the selected device's contents back onto the read bus.

Only the two most significant port bits take part in the decode, so the register and the flag each occupy a whole aliased range of ports. The memory takes its word address from the six low port bits. Reads are purely combinational: the read bus follows the port number within the same cycle, and the read pulse from the processor has no effect. The flag is returned zero-extended to the full data width.

Top module: `pbmap_top`

## Requirements
- R1: With port bits [7:6] = 00 the memory is selected and port bits [5:0] address one of its 64 words; a strobed write stores all 8 data bits, and `rd_data` shows the addressed word in the same cycle the port is presented.
- R2: With port bits [7:6] = 01 the data register is selected, so every port from 64 to 127 writes and reads the same 8-bit register.
- R3: With port bit 7 = 1 the flag is selected whatever bit 6 is, so every port from 128 to 255 reaches the same flag, and a write stores `wr_data[0]` only.
- R4: A device changes only on a clock edge where `wr_stb` is 1 and the port matches it; a matching port with `wr_stb` = 0 leaves every device unchanged.
- R5: At most one device is write-enabled in any cycle, and a write to one device leaves the other two unchanged, including writes to different devices on consecutive cycles.
- R6: The register and flag hold their value when not enabled; `rst` = 1 at a clock edge clears both to zero, while memory contents are not cleared.
- R7: Reading any flag port returns seven zero bits above the stored flag bit (bit 0).
- R8: `rd_stb` has no effect: `rd_data` always shows the device selected by the current `port_id`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all storage updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset of register and flag |
| port_id | input | 8 | Port number from the processor |
| wr_data | input | 8 | Output data from the processor |
| wr_stb | input | 1 | Write pulse, one cycle per write |
| rd_stb | input | 1 | Read pulse; ignored |
| rd_data | output | 8 | Read data returned to the processor |

## Verification
The two functions that share a cycle are the write into one device and the read-back path: on every strobed cycle the read multiplexer is already showing the newly selected device while the write enable for it is active, and on back-to-back writes one device's enable falls in the same edge as another's rises. The bench provokes this by issuing writes to the memory, register and flag on consecutive cycles with the strobe held high, then reading each device and every aliased port end to end. A scoreboard model updated only by strobed writes judges each read, so any cross-device disturbance or leaked enable shows as a miscompare.

// File: rtl/pbmap_pkg.sv
package pbmap_pkg;

   // Which local device the upper port bits currently point at.
   typedef enum logic [1:0] {
      TGT_WORDS = 2'd0,
      TGT_BYTE  = 2'd1,
      TGT_FLAG  = 2'd2
   } tgt_e;

   // Number of port bits consumed by the device decode.
   localparam int unsigned SEL_BITS = 2;

endpackage

// File: rtl/pbmap_decode.sv
module pbmap_decode
   import pbmap_pkg::*;
(
   input  logic                clk,
   input  logic                rst,
   input  logic [SEL_BITS-1:0] sel_bits,
   input  logic                wr_stb,
   output tgt_e                tgt,
   output logic                we_words,
   output logic                we_byte,
   output logic                we_flag
);

   // Partial decode: the top bit alone picks the flag, aliasing bit 6.
   always_comb begin
      if (sel_bits[1])
         tgt = TGT_FLAG;
      else if (sel_bits[0])
         tgt = TGT_BYTE;
      else
         tgt = TGT_WORDS;
   end

   always_comb begin
      we_words = wr_stb && (tgt == TGT_WORDS);
      we_byte  = wr_stb && (tgt == TGT_BYTE);
      we_flag  = wr_stb && (tgt == TGT_FLAG);
   end

   assert_one_we_R5 : assert property (@(posedge clk) disable iff (rst)
      $onehot0({we_words, we_byte, we_flag}));

   assert_we_needs_stb_R4 : assert property (@(posedge clk) disable iff (rst)
      !wr_stb |-> !(we_words || we_byte || we_flag));

endmodule

// File: rtl/pbmap_words.sv
module pbmap_words #(
   parameter int unsigned AW = 6,
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);

   localparam int unsigned DEPTH = 1 << AW;

   generate
      if (AW < 1 || AW > 10) begin : g_bad_depth
         $error("pbmap_words: AW out of supported range");
      end
   endgenerate

   logic [DW-1:0] store [DEPTH];

   // No reset on the array: contents survive a reset of the block.
   always_ff @(posedge clk) begin
      if (we)
         store[addr] <= wdata;
   end

   assign rdata = store[addr];

   assert_wr_lands_R1 : assert property (@(posedge clk) disable iff (rst)
      we |=> (addr != $past(addr)) || (rdata == $past(wdata)));

endmodule

// File: rtl/pbmap_hold.sv
module pbmap_hold #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         en,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (W < 1) begin : g_bad_width
         $error("pbmap_hold: W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)
         q <= '0;
      else if (en)
         q <= d;
   end

   assert_hold_R6 : assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(q));

   assert_load_R5 : assert property (@(posedge clk) disable iff (rst)
      en |=> (q == $past(d)));

endmodule

// File: rtl/pbmap_top.sv
module pbmap_top
   import pbmap_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned FLAG_BIT = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] port_id,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_stb,
   input  logic              rd_stb,
   output logic [DATA_W-1:0] rd_data
);

   localparam int unsigned MEM_AW = ADDR_W - SEL_BITS;

   generate
      if (ADDR_W <= SEL_BITS) begin : g_bad_addr
         $error("pbmap_top: ADDR_W too small for the device decode");
      end
      if (FLAG_BIT >= DATA_W) begin : g_bad_flag
         $error("pbmap_top: FLAG_BIT outside the data bus");
      end
   endgenerate

   // The read pulse carries no meaning for a combinational read path.
   logic unused_rd_stb;
   assign unused_rd_stb = rd_stb;

   tgt_e              tgt;
   logic              we_words, we_byte, we_flag;
   logic [DATA_W-1:0] words_q, byte_q;
   logic              flag_q;

   pbmap_decode u_decode (
      .clk      (clk),
      .rst      (rst),
      .sel_bits (port_id[ADDR_W-1 -: SEL_BITS]),
      .wr_stb   (wr_stb),
      .tgt      (tgt),
      .we_words (we_words),
      .we_byte  (we_byte),
      .we_flag  (we_flag)
   );

   pbmap_words #(.AW(MEM_AW), .DW(DATA_W)) u_words (
      .clk   (clk),
      .rst   (rst),
      .we    (we_words),
      .addr  (port_id[MEM_AW-1:0]),
      .wdata (wr_data),
      .rdata (words_q)
   );

   pbmap_hold #(.W(DATA_W)) u_byte (
      .clk (clk),
      .rst (rst),
      .en  (we_byte),
      .d   (wr_data),
      .q   (byte_q)
   );

   pbmap_hold #(.W(1)) u_flag (
      .clk (clk),
      .rst (rst),
      .en  (we_flag),
      .d   (wr_data[FLAG_BIT]),
      .q   (flag_q)
   );

   always_comb begin
      unique case (tgt)
         TGT_BYTE: rd_data = byte_q;
         TGT_FLAG: rd_data = {{(DATA_W-1){1'b0}}, flag_q};
         default:  rd_data = words_q;
      endcase
   end

   assert_flag_zext_R7 : assert property (@(posedge clk) disable iff (rst)
      port_id[ADDR_W-1] |-> (rd_data[DATA_W-1:1] == '0));

   assert_byte_alias_R2 : assert property (@(posedge clk) disable iff (rst)
      (port_id[ADDR_W-1 -: SEL_BITS] == 2'b01) |-> (rd_data == byte_q));

   assert_no_stb_R4 : assert property (@(posedge clk) disable iff (rst)
      !wr_stb |=> $stable(byte_q) && $stable(flag_q));

endmodule

// File: tb/pbmap_top_tb_top.sv
module pbmap_top_tb_top;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] port_id = 8'h00;
   logic [7:0] wr_data = 8'h00;
   logic       wr_stb = 1'b0;
   logic       rd_stb = 1'b0;
   logic [7:0] rd_data;

   always #2 clk = ~clk;   // 250 MHz

   pbmap_top dut_i (
      .clk     (clk),
      .rst     (rst),
      .port_id (port_id),
      .wr_data (wr_data),
      .wr_stb  (wr_stb),
      .rd_stb  (rd_stb),
      .rd_data (rd_data)
   );

   // Reference model built from the requirements.
   logic [7:0] m_words [64];
   logic [7:0] m_byte;
   logic       m_flag;

   // Scoreboard queues: expected value and requirement tag.
   logic [7:0] exp_q [$];
   string      tag_q [$];

   int n_vec  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   function automatic logic [7:0] model_rd(input logic [7:0] p);
      if (p[7])      return {7'b0, m_flag};
      else if (p[6]) return m_byte;
      else           return m_words[p[5:0]];
   endfunction

   task automatic bus_write(input logic [7:0] p, input logic [7:0] d);
      @(negedge clk);
      port_id = p;
      wr_data = d;
      wr_stb  = 1'b1;
      if (p[7])      m_flag = d[0];
      else if (p[6]) m_byte = d;
      else           m_words[p[5:0]] = d;
   endtask

   task automatic bus_idle();
      @(negedge clk);
      wr_stb = 1'b0;
   endtask

   // Port matches but no strobe: model stays as is.
   task automatic bus_nostrobe(input logic [7:0] p, input logic [7:0] d);
      @(negedge clk);
      port_id = p;
      wr_data = d;
      wr_stb  = 1'b0;
      rd_stb  = 1'b1;
   endtask

   task automatic bus_read(input logic [7:0] p, input logic rs, input string tag);
      @(negedge clk);
      port_id = p;
      wr_stb  = 1'b0;
      rd_stb  = rs;
      wr_data = ~wr_data;
      exp_q.push_back(model_rd(p));
      tag_q.push_back(tag);
   endtask

   // Monitor: compares one pending expectation per cycle, 1 ns after drive.
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (exp_q.size() > 0) begin
            logic [7:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_vec++;
            if (rd_data !== e) begin
               n_fail++;
               $display("FAIL %s port=%0d actual=%h expected=%h", t, port_id, rd_data, e);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run hung, actual=running expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   end

   initial begin
      m_byte = 8'h00;
      m_flag = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0;

      // R6: reset state of register and flag
      bus_read(8'd64, 1'b0, "R6");
      bus_read(8'd200, 1'b1, "R6");

      // R1: fill memory with distinct pattern, back-to-back writes
      for (int i = 0; i < 64; i++) bus_write(8'(i), 8'(i * 7 + 3));
      bus_idle();
      for (int i = 0; i < 64; i += 9) bus_read(8'(i), 1'b0, "R1");
      bus_read(8'd63, 1'b0, "R1");

      // R2: write at 64, read through aliases 64, 100, 127
      bus_write(8'd64, 8'hA5);
      bus_idle();
      bus_read(8'd64, 1'b0, "R2");
      bus_read(8'd127, 1'b0, "R2");
      bus_write(8'd127, 8'h3C);
      bus_idle();
      bus_read(8'd100, 1'b0, "R2");

      // R3: flag captures bit 0 only; aliases 128 and 255
      bus_write(8'd255, 8'hFF);
      bus_idle();
      bus_read(8'd128, 1'b0, "R3");
      bus_write(8'd128, 8'hFE);
      bus_idle();
      bus_read(8'd255, 1'b0, "R3");
      bus_write(8'd192, 8'h01);
      bus_idle();
      // R7: zero-extended flag readback
      bus_read(8'd130, 1'b0, "R7");
      bus_read(8'd191, 1'b1, "R7");

      // R4: matching ports without strobe leave everything unchanged
      bus_nostrobe(8'd70, 8'h11);
      bus_nostrobe(8'd140, 8'h00);
      bus_nostrobe(8'd5, 8'h99);
      bus_read(8'd70, 1'b0, "R4");
      bus_read(8'd140, 1'b0, "R4");
      bus_read(8'd5, 1'b0, "R4");

      // R5: consecutive writes to all three devices, then check each
      bus_write(8'd10, 8'h5A);
      bus_write(8'd65, 8'hC3);
      bus_write(8'd129, 8'h00);
      bus_write(8'd11, 8'h77);
      bus_idle();
      bus_read(8'd10, 1'b0, "R5");
      bus_read(8'd11, 1'b0, "R5");
      bus_read(8'd12, 1'b0, "R5");
      bus_read(8'd65, 1'b0, "R5");
      bus_read(8'd129, 1'b0, "R5");

      // R8: read strobe toggled on/off gives identical data
      bus_read(8'd65, 1'b1, "R8");
      bus_read(8'd65, 1'b0, "R8");
      bus_read(8'd11, 1'b1, "R8");

      // R6: mid-run reset clears register and flag, keeps memory
      bus_write(8'd150, 8'h01);
      bus_idle();
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      m_byte = 8'h00;
      m_flag = 1'b0;
      bus_read(8'd80, 1'b0, "R6");
      bus_read(8'd150, 1'b0, "R6");
      bus_read(8'd10, 1'b0, "R6");

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

endmodule